// File: doc/BRIEF.md
# Shift-Stage Operand Router

This block is the pipeline stage between register read and execute in a 32-bit processor. Each cycle it receives two operand words from register read, a result forwarded from the ALU, and a set of routing selects that have already been decoded. It registers two execute-stage operands and a shifter carry-out. A barrel shifter works on the second input word. A valid flag travels alongside the data.

Each outgoing operand register picks one of four sources: its pass-through value, its private stage buffer, the forwarded ALU result, or nothing. "Nothing" means the register keeps its old contents, so an immediate loaded earlier stays in place. For operand 1 the pass-through value is the raw first input word. For operand 2 it is the shifter output. Each of the two stage buffers either holds, captures its own raw input word, or captures the forwarded ALU result. An operand that selects its buffer sees the value the buffer held before the current edge. A stall freezes every register in the stage. A flush clears the valid flag.

Top module: `shift_route_stage`

## Requirements
- R1: While reset is asserted (rst_n low), op1_o, op2_o, carry_o and valid_o are 0, and both stage buffers are 0.
- R2: When not stalled, op1_sel_i selects what op1_o holds after the next rising edge: 0 gives data1_i, 1 gives the value held in buffer 1 before that edge, and 2 gives alu_fwd_i.
- R3: When not stalled, op2_sel_i uses the same codes for op2_o: 0 gives the shifter output, 1 gives the value held in buffer 2 before the edge, and 2 gives alu_fwd_i.
- R4: A select value of 3 on op1_sel_i or op2_sel_i makes that operand register keep its value. Each operand is handled independently, and an operand set to 3 holds even when the other operand loads.
- R5: When not stalled, buf1_sel_i and buf2_sel_i update their buffers. Code 0 or 3 holds the buffer. Code 1 captures the raw word (data1_i for buffer 1, data2_i for buffer 2). Code 2 captures alu_fwd_i. The new buffer value can be selected from the following cycle on.
- R6: The shifter is active only when shift_type_i is 1 (amount from shift_imm_i) or 2 (amount from data1_i[7:0]) and shift_dir_i is 1 (LSL), 2 (LSR), 3 (ASR) or 4 (ROR). In every other combination the shifter output equals data2_i and its carry equals carry_i.
- R7: An active shift by an amount of 0 returns data2_i unchanged, and its carry equals carry_i.
- R8: LSL and LSR by n from 1 to 31 shift in zeros, and the carry is the last bit shifted out. At n = 32 the result is 0, and the carry is bit 0 (LSL) or bit 31 (LSR). Above 32 the result and the carry are both 0.
- R9: ASR by n from 1 to 31 fills with the sign bit, and the carry is bit n-1. At 32 or more, every result bit and the carry equal bit 31.
- R10: ROR by n rotates right by n mod 32, and the carry equals bit 31 of the result. A nonzero multiple of 32 returns the value unchanged, with the carry equal to bit 31.
- R11: carry_o takes the shifter carry on every edge that is not stalled, whatever op2_sel_i is.
- R12: When stall_i is high, the buffers, op1_o, op2_o and carry_o keep their values.
- R13: valid_o takes in_valid_i on every edge that is not stalled. When flush_i is high, valid_o is 0 after the edge, even under a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze all stage registers |
| flush_i | input | 1 | Clear the valid flag |
| in_valid_i | input | 1 | Incoming instruction valid |
| data1_i | input | 32 | First operand word from register read |
| data2_i | input | 32 | Second operand word, shifter input |
| alu_fwd_i | input | 32 | Forwarded ALU result |
| op1_sel_i | input | 2 | Operand 1 source (0 thru, 1 buffer, 2 ALU, 3 hold) |
| op2_sel_i | input | 2 | Operand 2 source (0 shifter, 1 buffer, 2 ALU, 3 hold) |
| buf1_sel_i | input | 2 | Buffer 1 source (0/3 hold, 1 data1, 2 ALU) |
| buf2_sel_i | input | 2 | Buffer 2 source (0/3 hold, 1 data2, 2 ALU) |
| shift_type_i | input | 2 | 0 off, 1 immediate amount, 2 register amount |
| shift_dir_i | input | 3 | 0 none, 1 LSL, 2 LSR, 3 ASR, 4 ROR |
| shift_imm_i | input | 5 | Immediate shift amount |
| carry_i | input | 1 | Incoming carry flag |
| op1_o | output | 32 | Execute operand 1 |
| op2_o | output | 32 | Execute operand 2 |
| carry_o | output | 1 | Registered shifter carry-out |
| valid_o | output | 1 | Registered valid flag |

## Verification
The bench first runs every operand-select and buffer-select pairing on both lanes. A design that let an operand read the buffer's new value in the same cycle, or that made the hold code load anything, would show a wrong operand on the following cycle. It then shifts by 0, 1, 31, 32, 33 and 200 in all four directions. The edges at 32 and above expose a shifter that wraps the amount or takes its carry from the wrong bit, and amount 0 exposes one that clears the carry instead of passing it through. The remaining cycles cover inactive type and direction codes, stalls with busy inputs (a buffer that is not frozen shows up when it is read back after the stall), and flush with and without a stall.

// File: rtl/srs_pkg.sv
package srs_pkg;

   typedef enum logic [1:0] {
      OPS_THRU = 2'd0,
      OPS_BUF  = 2'd1,
      OPS_ALU  = 2'd2,
      OPS_NONE = 2'd3
   } op_src_e;

   typedef enum logic [1:0] {
      BFS_HOLD = 2'd0,
      BFS_THRU = 2'd1,
      BFS_ALU  = 2'd2,
      BFS_RSVD = 2'd3
   } buf_src_e;

   typedef enum logic [1:0] {
      SHT_OFF  = 2'd0,
      SHT_IMM  = 2'd1,
      SHT_REG  = 2'd2,
      SHT_RSVD = 2'd3
   } sh_type_e;

   typedef enum logic [2:0] {
      SHD_NONE = 3'd0,
      SHD_LSL  = 3'd1,
      SHD_LSR  = 3'd2,
      SHD_ASR  = 3'd3,
      SHD_ROR  = 3'd4,
      SHD_R5   = 3'd5,
      SHD_R6   = 3'd6,
      SHD_R7   = 3'd7
   } sh_dir_e;

   function automatic logic dir_is_shift(input sh_dir_e d);
      return (d == SHD_LSL) || (d == SHD_LSR) || (d == SHD_ASR) || (d == SHD_ROR);
   endfunction

endpackage

// File: rtl/srs_shifter.sv
module srs_shifter
   import srs_pkg::*;
#(
   parameter int DW         = 32,
   parameter int AMTW       = 8,
   parameter bit ROT_STAGED = 1'b1
) (
   input  logic [DW-1:0]   value_i,
   input  logic [AMTW-1:0] amt_i,
   input  sh_dir_e         dir_i,
   input  logic            active_i,
   input  logic            cin_i,
   output logic [DW-1:0]   res_o,
   output logic            cout_o
);
   localparam int LW = $clog2(DW);

   initial begin
      assert ((1 << LW) == DW && DW >= 8)
         else $error("srs_shifter: DW must be a power of two, at least 8");
      assert (AMTW > LW)
         else $error("srs_shifter: AMTW must exceed log2(DW)");
   end

   logic [LW-1:0]     rot_k;
   logic [DW-1:0]     rot_v;
   logic [DW:0]       lsl_w;
   logic [DW:0]       lsr_w;
   logic signed [DW:0] asr_w;

   assign rot_k = amt_i[LW-1:0];

   generate
      if (ROT_STAGED) begin : g_rot_staged
         logic [DW-1:0] stage [LW+1];
         assign stage[0] = value_i;
         for (genvar s = 0; s < LW; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stage[s+1] = rot_k[s] ? {stage[s][SH-1:0], stage[s][DW-1:SH]}
                                         : stage[s];
         end
         assign rot_v = stage[LW];
      end else begin : g_rot_flat
         logic [2*DW-1:0] dbl;
         assign dbl   = {value_i, value_i} >> rot_k;
         assign rot_v = dbl[DW-1:0];
      end
   endgenerate

   // one extra bit beside the word catches the last bit shifted out
   assign lsl_w = {1'b0, value_i} << amt_i;
   assign lsr_w = {value_i, 1'b0} >> amt_i;
   assign asr_w = $signed({value_i, 1'b0}) >>> amt_i;

   always_comb begin
      res_o  = value_i;
      cout_o = cin_i;
      if (active_i && (amt_i != '0)) begin
         unique case (dir_i)
            SHD_LSL: {cout_o, res_o} = lsl_w;
            SHD_LSR: {res_o, cout_o} = lsr_w;
            SHD_ASR: {res_o, cout_o} = asr_w;
            SHD_ROR: begin
               res_o  = rot_v;
               cout_o = rot_v[DW-1];
            end
            default: begin
               res_o  = value_i;
               cout_o = cin_i;
            end
         endcase
      end
   end

endmodule

// File: rtl/srs_buffer.sv
module srs_buffer
   import srs_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall_i,
   input  buf_src_e      sel_i,
   input  logic [DW-1:0] thru_i,
   input  logic [DW-1:0] alu_i,
   output logic [DW-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (!stall_i) begin
         unique case (sel_i)
            BFS_THRU: q_o <= thru_i;
            BFS_ALU:  q_o <= alu_i;
            default:  q_o <= q_o;
         endcase
      end
   end

   AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i || sel_i == BFS_HOLD || sel_i == BFS_RSVD) |=> $stable(q_o)); // R5

   AST_BUF_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && sel_i == BFS_ALU) |=> (q_o == $past(alu_i))); // R5

endmodule

// File: rtl/srs_opreg.sv
module srs_opreg
   import srs_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall_i,
   input  op_src_e       sel_i,
   input  logic [DW-1:0] thru_i,
   input  logic [DW-1:0] buf_i,
   input  logic [DW-1:0] alu_i,
   output logic [DW-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (!stall_i) begin
         unique case (sel_i)
            OPS_THRU: q_o <= thru_i;
            OPS_BUF:  q_o <= buf_i;
            OPS_ALU:  q_o <= alu_i;
            default:  q_o <= q_o;
         endcase
      end
   end

   AST_OP_NONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == OPS_NONE) |=> $stable(q_o)); // R4

   AST_OP_OLD_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && sel_i == OPS_BUF) |=> (q_o == $past(buf_i))); // R2

   AST_OP_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && sel_i == OPS_ALU) |=> (q_o == $past(alu_i))); // R3

endmodule

// File: rtl/shift_route_stage.sv
module shift_route_stage
   import srs_pkg::*;
#(
   parameter int DW         = 32,
   parameter int AMTW       = 8,
   parameter int SHW        = 5,
   parameter bit ROT_STAGED = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall_i,
   input  logic            flush_i,
   input  logic            in_valid_i,
   input  logic [DW-1:0]   data1_i,
   input  logic [DW-1:0]   data2_i,
   input  logic [DW-1:0]   alu_fwd_i,
   input  logic [1:0]      op1_sel_i,
   input  logic [1:0]      op2_sel_i,
   input  logic [1:0]      buf1_sel_i,
   input  logic [1:0]      buf2_sel_i,
   input  logic [1:0]      shift_type_i,
   input  logic [2:0]      shift_dir_i,
   input  logic [SHW-1:0]  shift_imm_i,
   input  logic            carry_i,
   output logic [DW-1:0]   op1_o,
   output logic [DW-1:0]   op2_o,
   output logic            carry_o,
   output logic            valid_o
);
   localparam int LANES = 2;

   initial begin
      assert (SHW == $clog2(DW))
         else $error("shift_route_stage: SHW must equal log2(DW)");
      assert (AMTW > SHW && AMTW <= DW)
         else $error("shift_route_stage: AMTW out of range");
   end

   sh_type_e        sh_type;
   sh_dir_e         sh_dir;
   logic            sh_active;
   logic [AMTW-1:0] sh_amt;
   logic [DW-1:0]   sh_res;
   logic            sh_cout;

   assign sh_type   = sh_type_e'(shift_type_i);
   assign sh_dir    = sh_dir_e'(shift_dir_i);
   assign sh_active = ((sh_type == SHT_IMM) || (sh_type == SHT_REG)) && dir_is_shift(sh_dir);
   assign sh_amt    = (sh_type == SHT_IMM) ? {{(AMTW-SHW){1'b0}}, shift_imm_i}
                                           : data1_i[AMTW-1:0];

   srs_shifter #(.DW(DW), .AMTW(AMTW), .ROT_STAGED(ROT_STAGED)) u_shifter (
      .value_i  (data2_i),
      .amt_i    (sh_amt),
      .dir_i    (sh_dir),
      .active_i (sh_active),
      .cin_i    (carry_i),
      .res_o    (sh_res),
      .cout_o   (sh_cout)
   );

   logic [DW-1:0] lane_op_thru  [LANES];
   logic [DW-1:0] lane_buf_thru [LANES];
   logic [DW-1:0] lane_buf_q    [LANES];
   logic [DW-1:0] lane_op_q     [LANES];
   logic [1:0]    lane_op_sel   [LANES];
   logic [1:0]    lane_buf_sel  [LANES];

   assign lane_op_thru[0]  = data1_i;
   assign lane_op_thru[1]  = sh_res;
   assign lane_buf_thru[0] = data1_i;
   assign lane_buf_thru[1] = data2_i;
   assign lane_op_sel[0]   = op1_sel_i;
   assign lane_op_sel[1]   = op2_sel_i;
   assign lane_buf_sel[0]  = buf1_sel_i;
   assign lane_buf_sel[1]  = buf2_sel_i;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         srs_buffer #(.DW(DW)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .stall_i (stall_i),
            .sel_i   (buf_src_e'(lane_buf_sel[g])),
            .thru_i  (lane_buf_thru[g]),
            .alu_i   (alu_fwd_i),
            .q_o     (lane_buf_q[g])
         );
         srs_opreg #(.DW(DW)) u_op (
            .clk     (clk),
            .rst_n   (rst_n),
            .stall_i (stall_i),
            .sel_i   (op_src_e'(lane_op_sel[g])),
            .thru_i  (lane_op_thru[g]),
            .buf_i   (lane_buf_q[g]),
            .alu_i   (alu_fwd_i),
            .q_o     (lane_op_q[g])
         );
      end
   endgenerate

   assign op1_o = lane_op_q[0];
   assign op2_o = lane_op_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_o <= 1'b0;
      end else if (!stall_i) begin
         carry_o <= sh_cout;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
      end else if (flush_i) begin
         valid_o <= 1'b0;
      end else if (!stall_i) begin
         valid_o <= in_valid_i;
      end
   end

   AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && !sh_active) |=> (carry_o == $past(carry_i))); // R6

   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && !sh_active && op2_sel_i == 2'd0) |=> (op2_o == $past(data2_i))); // R6

   AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && sh_active && sh_amt == '0 && op2_sel_i == 2'd0)
         |=> (carry_o == $past(carry_i) && op2_o == $past(data2_i))); // R7

   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> ($stable(op1_o) && $stable(op2_o) && $stable(carry_o))); // R12

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !valid_o); // R13

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && !flush_i) |=> (valid_o == $past(in_valid_i))); // R13

endmodule

// File: tb/shift_route_stage_test.sv
`timescale 1ns/1ps
module shift_route_stage_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall_i = 0, flush_i = 0, in_valid_i = 0;
   logic [31:0] data1_i = 0, data2_i = 0, alu_fwd_i = 0;
   logic [1:0]  op1_sel_i = 0, op2_sel_i = 0, buf1_sel_i = 0, buf2_sel_i = 0;
   logic [1:0]  shift_type_i = 0;
   logic [2:0]  shift_dir_i = 0;
   logic [4:0]  shift_imm_i = 0;
   logic        carry_i = 0;
   logic [31:0] op1_o, op2_o;
   logic        carry_o, valid_o;

   always #2 clk = ~clk;

   shift_route_stage uut (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .flush_i(flush_i),
      .in_valid_i(in_valid_i), .data1_i(data1_i), .data2_i(data2_i),
      .alu_fwd_i(alu_fwd_i), .op1_sel_i(op1_sel_i), .op2_sel_i(op2_sel_i),
      .buf1_sel_i(buf1_sel_i), .buf2_sel_i(buf2_sel_i),
      .shift_type_i(shift_type_i), .shift_dir_i(shift_dir_i),
      .shift_imm_i(shift_imm_i), .carry_i(carry_i),
      .op1_o(op1_o), .op2_o(op2_o), .carry_o(carry_o), .valid_o(valid_o)
   );

   typedef struct {
      logic [31:0] op1;
      logic [31:0] op2;
      logic        c;
      logic        v;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_tests = 0;
   int    n_fail  = 0;
   bit    finished = 0;

   // model state
   logic [31:0] m_op1 = 0, m_op2 = 0, m_b1 = 0, m_b2 = 0;
   logic        m_c = 0, m_v = 0;

   // bit-serial reference: one position per step, carry is the last bit out
   function automatic logic [32:0] ref_shift(input logic [31:0] v, input int amt,
                                             input int dir, input logic cin);
      logic c = cin;
      for (int i = 0; i < amt; i++) begin
         case (dir)
            1: begin c = v[31]; v = {v[30:0], 1'b0}; end
            2: begin c = v[0];  v = {1'b0, v[31:1]}; end
            3: begin c = v[0];  v = {v[31], v[31:1]}; end
            default: begin c = v[0]; v = {v[0], v[31:1]}; end
         endcase
      end
      return {c, v};
   endfunction

   task automatic step(input logic [31:0] d1, input logic [31:0] d2, input logic [31:0] alu,
                       input int s1, input int s2, input int b1, input int b2,
                       input int st, input int sd, input int imm, input logic cin,
                       input logic iv, input logic stl, input logic fl, input string tag);
      logic        act;
      int          amt;
      logic [32:0] r;
      logic [31:0] thru2;
      logic        cn;
      exp_t        e;
      data1_i = d1; data2_i = d2; alu_fwd_i = alu;
      op1_sel_i = 2'(s1); op2_sel_i = 2'(s2); buf1_sel_i = 2'(b1); buf2_sel_i = 2'(b2);
      shift_type_i = 2'(st); shift_dir_i = 3'(sd); shift_imm_i = 5'(imm);
      carry_i = cin; in_valid_i = iv; stall_i = stl; flush_i = fl;
      act = (st == 1 || st == 2) && (sd >= 1 && sd <= 4);
      amt = (st == 1) ? (imm & 31) : int'(d1[7:0]);
      if (act) begin
         r = ref_shift(d2, amt, sd, cin);
         thru2 = r[31:0]; cn = r[32];
      end else begin
         thru2 = d2; cn = cin;
      end
      if (!stl) begin
         case (s1) 0: m_op1 = d1; 1: m_op1 = m_b1; 2: m_op1 = alu; default: ; endcase
         case (s2) 0: m_op2 = thru2; 1: m_op2 = m_b2; 2: m_op2 = alu; default: ; endcase
         case (b1) 1: m_b1 = d1; 2: m_b1 = alu; default: ; endcase
         case (b2) 1: m_b2 = d2; 2: m_b2 = alu; default: ; endcase
         m_c = cn;
         m_v = iv;
      end
      if (fl) m_v = 1'b0;
      e.op1 = m_op1; e.op2 = m_op2; e.c = m_c; e.v = m_v;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   // monitor: compares one item per cycle, shortly after the active edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_tests++;
         if (op1_o !== e.op1 || op2_o !== e.op2 || carry_o !== e.c || valid_o !== e.v) begin
            n_fail++;
            $display("FAIL %s: act op1=%h op2=%h c=%b v=%b exp op1=%h op2=%h c=%b v=%b",
                     t, op1_o, op2_o, carry_o, valid_o, e.op1, e.op2, e.c, e.v);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_fail++;
         $display("FAIL watchdog: act running exp done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int amts[6] = '{0, 1, 31, 32, 33, 200};
      int imms[3] = '{0, 1, 31};
      logic [31:0] pat;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_tests++;
      if (op1_o !== 0 || op2_o !== 0 || carry_o !== 0 || valid_o !== 0) begin
         n_fail++;
         $display("FAIL R1: act op1=%h op2=%h c=%b v=%b exp all zero", op1_o, op2_o, carry_o, valid_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R1: buffers read back as zero right after reset
      step(32'h11, 32'h22, 32'h33, 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R1 buffers");

      // R2 R3 R4 R5: every operand-select by buffer-select pairing
      for (int o = 0; o < 4; o++) begin
         for (int b = 0; b < 4; b++) begin
            step($urandom, $urandom, $urandom, o, o, b, b, 0, 0, 0, 0, 1, 0, 0,
                 (o == 3) ? "R4 hold" : "R2/R3/R5 pairing");
            step($urandom, $urandom, $urandom, 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0,
                 "R5 buffer readback");
         end
      end
      // R4: one operand holds while the other loads
      step(32'hAAAA0001, 32'hBBBB0002, 32'hCCCC0003, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R4 load");
      step(32'h1, 32'h2, 32'h3, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R4 op1 holds");
      step(32'h4, 32'h5, 32'h6, 0, 3, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R4 op2 holds");
      // R3: shifter output on operand 2 with an alternate buffer pattern
      for (int o = 0; o < 4; o++)
         step($urandom, $urandom, $urandom, o, o, 2 - (o % 3), (o + 1) % 3,
              1, 1, 1, 0, 1, 0, 0, "R3 shifted thru");

      // R7 R8 R9 R10 R11: register-amount edges in each direction
      for (int d = 1; d <= 4; d++) begin
         for (int a = 0; a < 6; a++) begin
            for (int p = 0; p < 2; p++) begin
               pat = (p == 0) ? 32'h8000_0001 : $urandom;
               step({24'h0, 8'(amts[a])}, pat, 32'h0, 0, 0, 0, 0, 2, d, 0, p[0], 1, 0, 0,
                    (amts[a] == 0) ? "R7/R11 zero amount" :
                    (d <= 2) ? "R8/R11 logical" : (d == 3) ? "R9/R11 arith" : "R10/R11 rotate");
            end
         end
         for (int a = 0; a < 3; a++)
            step(32'hFFFF_FFFF, 32'hC000_0003, 32'h0, 0, 0, 0, 0, 1, d, imms[a], 1'b1, 1, 0, 0,
                 (imms[a] == 0) ? "R7 imm zero" : "R8/R9/R10 imm amount");
      end
      // R10: multiples of 32 leave value unchanged, carry bit 31
      step(32'h40, 32'h7000_0001, 0, 0, 0, 0, 0, 2, 4, 0, 1'b1, 1, 0, 0, "R10 rotate 64");
      step(32'h20, 32'h8000_0000, 0, 0, 0, 0, 0, 2, 4, 0, 1'b0, 1, 0, 0, "R10 rotate 32");

      // R6: inactive type/direction combinations pass data2 and carry_i
      step(32'h3, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 1, 3, 1'b1, 1, 0, 0, "R6 type off");
      step(32'h3, 32'h1234_5678, 0, 0, 0, 0, 0, 1, 0, 3, 1'b0, 1, 0, 0, "R6 dir none");
      step(32'h3, 32'h8765_4321, 0, 0, 0, 0, 0, 3, 2, 3, 1'b1, 1, 0, 0, "R6 type reserved");
      step(32'h3, 32'h8765_4321, 0, 0, 0, 0, 0, 2, 5, 3, 1'b0, 1, 0, 0, "R6 dir reserved");

      // R12: stall freezes outputs and buffers
      step(32'h0101_0101, 32'h0202_0202, 32'h0303_0303, 0, 0, 1, 1, 0, 0, 0, 1'b1, 1, 0, 0, "R12 preload");
      for (int k = 0; k < 3; k++)
         step($urandom, $urandom, $urandom, k % 3, 0, 2, 2, 2, 1, 0, 1'b0, 1, 1, 0, "R12 stalled");
      step(32'h0, 32'h0, 32'h0, 1, 1, 0, 0, 0, 0, 0, 1'b0, 1, 0, 0, "R12 buffers frozen");

      // R13: valid follows, flush clears, flush under stall clears
      step(1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R13 valid set");
      step(1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R13 flush");
      step(1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R13 valid again");
      step(1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R13 flush under stall");
      step(1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R13 valid low");

      // mixed random traffic
      for (int k = 0; k < 300; k++)
         step($urandom, $urandom, $urandom, $urandom % 4, $urandom % 4, $urandom % 4,
              $urandom % 4, $urandom % 4, $urandom % 8, $urandom % 32, 1'($urandom),
              1'($urandom), ($urandom % 5) == 0, ($urandom % 7) == 0, "R2/R3/R6/R11 random");

      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule